// File: doc/BRIEF.md
# Expansion ROM Base Address Register and Window Decoder

This block holds the expansion ROM base address register of one function's configuration space and decodes the memory window that the register describes. Configuration software reaches the register through a simple access port: a dword index, per-byte enables and 32-bit data. The block answers reads to its own dword and stays silent for every other index.

Address bits below the ROM size are wired to zero. Software can therefore find the ROM size by writing all ones and reading the value back. After that it places the ROM at a naturally aligned base and sets the decode enable.

On the memory side the block watches a 32-bit access address. It raises a hit when the address falls inside the programmed window, and it gives the byte offset within the ROM. A hit needs the register's own enable bit and the memory space enable from the command register, both at 1. The ROM size is a power-of-two parameter between 2 KB and 16 MB. Any other value is rejected at elaboration.

Top module: `rom_window_decoder`

## Requirements
- R1: A read with `cfg_rd_en` high and `cfg_dw_idx` equal to 12 (byte offset 0x30) drives the register value on `cfg_rdata` and raises `cfg_rvalid` in the same cycle.
- R2: After reset the register reads 0x00000000, so the enable is 0 and the base is 0.
- R3: Bit 0 is the decode enable. It can be written and read back.
- R4: Bits 10:1, and every address bit below log2(ROM_BYTES), always read 0. Writes to them are ignored.
- R5: With ROM_BYTES = 131072, writing 0xFFFFFFFE reads back as 0xFFFE0000.
- R6: Byte enable bit n (covering data bits 8n+7:8n) gates the write of that byte. Bytes whose enable is 0 keep their value.
- R7: `rom_hit` is 1 only while both `cmd_mem_en` and the decode enable are 1.
- R8: With both enables set, `rom_hit` is 1 exactly when the bits of `mem_addr` at or above log2(ROM_BYTES) equal the stored base. `rom_offset` equals `mem_addr` bits below log2(ROM_BYTES).
- R9: A read of any other dword index gives `cfg_rdata` = 0 and `cfg_rvalid` = 0. A write to any other index leaves the register unchanged.
- R10: A write to the register does not change `rom_hit` in the cycle of the write. The new base and enable apply from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_dw_idx | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, zero when not selected |
| cfg_rvalid | output | 1 | High when this block answers a read |
| cmd_mem_en | input | 1 | Memory space enable from the command register |
| mem_addr | input | 32 | Memory access address |
| rom_hit | output | 1 | Access falls in the enabled ROM window |
| rom_offset | output | log2(ROM_BYTES) | Byte offset within the ROM |

## Verification
The hardest case to reach is the single cycle in which a register write and a memory access overlap. The write must not yet move the window, and one cycle later the access must see the new base. The bench holds an address inside the new window, arms the write together with the command enable, and samples `rom_hit` before the clock edge and again after it. Partial writes are also hard to check: the writable bits are split across byte lanes with hardwired zeros between them. The bench drives single-lane writes with patterns that set the fixed-zero bits in the same byte.

// File: rtl/rom_window_pkg.sv
package rom_window_pkg;

  localparam int          DATA_W    = 32;
  localparam int          IDX_W     = 6;
  localparam int          LANES     = DATA_W / 8;
  localparam logic [IDX_W-1:0] BAR_DWORD = 6'd12;

  // Ones at and above the size boundary.
  function automatic logic [DATA_W-1:0] size_mask(input int lg);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i >= lg);
    return m;
  endfunction

  // Bits software may change: the aligned base plus the enable bit.
  function automatic logic [DATA_W-1:0] writable_mask(input int lg);
    return size_mask(lg) | {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  // Expand byte enables into a bit mask.
  function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic bit size_ok(input longint bytes);
    return (bytes >= 2048) && (bytes <= 16777216) && ((bytes & (bytes - 1)) == 0);
  endfunction

endpackage

// File: rtl/rom_cfg_port.sv
module rom_cfg_port
  import rom_window_pkg::*;
(
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [IDX_W-1:0]  cfg_dw_idx,
  input  logic [DATA_W-1:0] bar_q,
  output logic              bar_wr_stb,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              cfg_rvalid
);

  logic sel;

  always_comb begin
    sel        = (cfg_dw_idx == BAR_DWORD);
    bar_wr_stb = cfg_wr_en & sel;
    cfg_rvalid = cfg_rd_en & sel;
    cfg_rdata  = cfg_rvalid ? bar_q : '0;
  end

endmodule

// File: rtl/rom_bar_reg.sv
module rom_bar_reg
  import rom_window_pkg::*;
#(
  parameter int SIZE_LOG2 = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] bar_q
);

  localparam logic [DATA_W-1:0] WMASK = writable_mask(SIZE_LOG2);

  logic [DATA_W-1:0] upd_mask;

  always_comb upd_mask = lane_mask(be) & WMASK;

  always_ff @(posedge clk) begin
    if (!rst_n)      bar_q <= '0;
    else if (wr_stb) bar_q <= (bar_q & ~upd_mask) | (wdata & upd_mask);
  end

endmodule

// File: rtl/rom_addr_match.sv
module rom_addr_match
  import rom_window_pkg::*;
#(
  parameter int SIZE_LOG2 = 17
) (
  input  logic                 cmd_mem_en,
  input  logic [DATA_W-1:0]    mem_addr,
  input  logic [DATA_W-1:0]    bar_q,
  output logic                 dec_en,
  output logic                 addr_in_win,
  output logic                 rom_hit,
  output logic [SIZE_LOG2-1:0] rom_offset
);

  localparam logic [DATA_W-1:0] SMASK = size_mask(SIZE_LOG2);

  always_comb begin
    dec_en      = bar_q[0] & cmd_mem_en;
    addr_in_win = ((mem_addr ^ bar_q) & SMASK) == '0;
    rom_hit     = dec_en & addr_in_win;
    rom_offset  = mem_addr[SIZE_LOG2-1:0];
  end

endmodule

// File: rtl/rom_window_decoder.sv
module rom_window_decoder
  import rom_window_pkg::*;
#(
  parameter int ROM_BYTES = 131072,
  localparam int SIZE_LOG2 = $clog2(ROM_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic                 cfg_rd_en,
  input  logic [5:0]           cfg_dw_idx,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic                 cfg_rvalid,
  input  logic                 cmd_mem_en,
  input  logic [31:0]          mem_addr,
  output logic                 rom_hit,
  output logic [SIZE_LOG2-1:0] rom_offset
);

  generate
    if (!size_ok(ROM_BYTES)) begin : g_bad_size
      $error("ROM_BYTES must be a power of two from 2048 to 16777216");
    end
  endgenerate

  logic [DATA_W-1:0] bar_q;
  logic              bar_wr_stb;
  logic              dec_en;
  logic              addr_in_win;

  rom_cfg_port u_cfg (
    .cfg_wr_en  (cfg_wr_en),
    .cfg_rd_en  (cfg_rd_en),
    .cfg_dw_idx (cfg_dw_idx),
    .bar_q      (bar_q),
    .bar_wr_stb (bar_wr_stb),
    .cfg_rdata  (cfg_rdata),
    .cfg_rvalid (cfg_rvalid)
  );

  rom_bar_reg #(.SIZE_LOG2(SIZE_LOG2)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (bar_wr_stb),
    .be     (cfg_be),
    .wdata  (cfg_wdata),
    .bar_q  (bar_q)
  );

  rom_addr_match #(.SIZE_LOG2(SIZE_LOG2)) u_match (
    .cmd_mem_en  (cmd_mem_en),
    .mem_addr    (mem_addr),
    .bar_q       (bar_q),
    .dec_en      (dec_en),
    .addr_in_win (addr_in_win),
    .rom_hit     (rom_hit),
    .rom_offset  (rom_offset)
  );

endmodule

// File: rtl/rom_window_checker.sv
module rom_window_checker #(
  parameter int ROM_BYTES = 131072
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic        cfg_rd_en,
  input logic [5:0]  cfg_dw_idx,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_rdata,
  input logic        cfg_rvalid,
  input logic        cmd_mem_en,
  input logic        rom_hit,
  input logic        addr_in_win,
  input logic [31:0] bar_val,
  input logic        bar_wr
);

  localparam int LG = $clog2(ROM_BYTES);
  localparam logic [31:0] FIXED_ZERO = ((32'd1 << LG) - 32'd1) & 32'hFFFF_FFFE;

  assert_rvalid_on_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_en && cfg_dw_idx == 6'd12) |-> cfg_rvalid);

  assert_fixed_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_val & FIXED_ZERO) == 32'd0);

  assert_byte_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_wr && !cfg_be[3]) |=> $stable(bar_val[31:24]));

  assert_hit_needs_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit |-> cmd_mem_en);

  assert_hit_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit |-> bar_val[0]);

  assert_hit_needs_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit |-> addr_in_win);

  assert_other_index_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_rd_en && cfg_dw_idx == 6'd12) |-> (!cfg_rvalid && cfg_rdata == 32'd0));

  assert_other_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_dw_idx != 6'd12) |=> $stable(bar_val));

endmodule

bind rom_window_decoder rom_window_checker #(.ROM_BYTES(ROM_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_rd_en   (cfg_rd_en),
  .cfg_dw_idx  (cfg_dw_idx),
  .cfg_be      (cfg_be),
  .cfg_rdata   (cfg_rdata),
  .cfg_rvalid  (cfg_rvalid),
  .cmd_mem_en  (cmd_mem_en),
  .rom_hit     (rom_hit),
  .addr_in_win (addr_in_win),
  .bar_val     (bar_q),
  .bar_wr      (bar_wr_stb)
);

// File: tb/tb_rom_window_decoder.sv
module tb_rom_window_decoder;

  localparam int ROM_BYTES = 131072;
  localparam int LG = 17;
  localparam logic [31:0] WMASK = ~(ROM_BYTES - 1) | 32'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
  logic [5:0]  cfg_dw_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic        cmd_mem_en = 1'b0;
  logic [31:0] mem_addr = '0;
  logic        rom_hit;
  logic [LG-1:0] rom_offset;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] mdl = '0;

  always #10 clk = ~clk;

  rom_window_decoder #(.ROM_BYTES(ROM_BYTES)) dut (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  task automatic mdl_write(input logic [3:0] be, input logic [31:0] d);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++) if (be[i]) m |= 32'hFF << (8 * i);
    m &= WMASK;
    mdl = (mdl & ~m) | (d & m);
  endtask

  task automatic cfg_write(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_dw_idx = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 0;
    if (idx == 6'd12) mdl_write(be, d);
  endtask

  task automatic cfg_read(input logic [5:0] idx, output logic [31:0] d, output logic v);
    cfg_rd_en = 1; cfg_dw_idx = idx;
    #2;
    d = cfg_rdata; v = cfg_rvalid;
    cfg_rd_en = 0;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic v;
    cfg_read(6'd12, d, v);
    check("R2 reset value", d, 32'h0);
    check("R1 rvalid", {31'd0, v}, 32'd1);
    cmd_mem_en = 1; mem_addr = 32'h0; #2;
    check("R2 no hit after reset", {31'd0, rom_hit}, 32'd0);
    cmd_mem_en = 0;
  endtask

  task automatic t_probe();
    logic [31:0] d; logic v;
    cfg_write(6'd12, 4'hF, 32'hFFFF_FFFE);
    cfg_read(6'd12, d, v);
    check("R5 size probe", d, 32'hFFFE_0000);
    check("R4 fixed zero bits", d & 32'h0001_FFFE, 32'h0);
    cfg_write(6'd12, 4'hF, 32'hFFFF_FFFF);
    cfg_read(6'd12, d, v);
    check("R3 enable readback", d, 32'hFFFE_0001);
    cfg_write(6'd12, 4'hF, 32'h0000_07FE);
    cfg_read(6'd12, d, v);
    check("R4 reserved writes ignored", d, 32'h0);
  endtask

  task automatic t_bytes();
    logic [31:0] d; logic v;
    cfg_write(6'd12, 4'b0100, 32'hAABB_CCDD);
    cfg_read(6'd12, d, v);
    check("R6 lane2 only", d, 32'h00BA_0000);
    check("R6 model", d, mdl);
    cfg_write(6'd12, 4'b0001, 32'hFFFF_FF01);
    cfg_read(6'd12, d, v);
    check("R6 lane0 only", d, 32'h00BA_0001);
    cfg_write(6'd12, 4'b0000, 32'hFFFF_FFFF);
    cfg_read(6'd12, d, v);
    check("R6 no lanes", d, 32'h00BA_0001);
  endtask

  task automatic t_decode();
    cmd_mem_en = 1;
    mem_addr = 32'h00BA_1234; #2;
    check("R8 hit inside", {31'd0, rom_hit}, 32'd1);
    check("R8 offset", {15'd0, rom_offset}, 32'h0_1234);
    mem_addr = 32'h00BB_FFFF; #2;
    check("R8 hit top", {31'd0, rom_hit}, 32'd1);
    check("R8 offset top", {15'd0, rom_offset}, 32'h1_FFFF);
    mem_addr = 32'h00BC_0000; #2;
    check("R8 miss above", {31'd0, rom_hit}, 32'd0);
    mem_addr = 32'h00B9_FFFF; #2;
    check("R8 miss below", {31'd0, rom_hit}, 32'd0);
    mem_addr = 32'h80BA_0000; #2;
    check("R8 miss high bit", {31'd0, rom_hit}, 32'd0);
  endtask

  task automatic t_gate();
    mem_addr = 32'h00BA_0010;
    cmd_mem_en = 0; #2;
    check("R7 cmd off", {31'd0, rom_hit}, 32'd0);
    cmd_mem_en = 1;
    cfg_write(6'd12, 4'b0001, 32'h0);
    #2;
    check("R7 enable off", {31'd0, rom_hit}, 32'd0);
  endtask

  task automatic t_other();
    logic [31:0] d; logic v;
    cfg_write(6'd11, 4'hF, 32'hFFFF_FFFF);
    cfg_write(6'd13, 4'hF, 32'h1234_5679);
    cfg_read(6'd11, d, v);
    check("R9 other rdata", d, 32'h0);
    check("R9 other rvalid", {31'd0, v}, 32'd0);
    cfg_read(6'd12, d, v);
    check("R9 register untouched", d, 32'h00BA_0000);
  endtask

  task automatic t_timing();
    @(negedge clk);
    cmd_mem_en = 1; mem_addr = 32'h0042_0100;
    cfg_wr_en = 1; cfg_dw_idx = 6'd12; cfg_be = 4'hF; cfg_wdata = 32'h0042_0001;
    #2;
    check("R10 same cycle old", {31'd0, rom_hit}, 32'd0);
    @(negedge clk);
    cfg_wr_en = 0; mdl_write(4'hF, 32'h0042_0001);
    #2;
    check("R10 next cycle new", {31'd0, rom_hit}, 32'd1);
    check("R8 offset new base", {15'd0, rom_offset}, 32'h0_0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_probe();
    t_bytes();
    t_decode();
    t_gate();
    t_other();
    t_timing();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

endmodule